// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block turns a 32-bit virtual address into a physical address for a processor whose address space is carved into fixed segments. The top bit of the address separates the low user region from the kernel half; the kernel half is split again into an unmapped window, which is reduced to a 512 MiB physical alias, and a mapped window. Each request also carries a user-mode flag, an error-level flag and a 2-bit translation mode. The mode chooses how the mapped regions are resolved: pass-through, a fixed offset, or a lookup in an external translation buffer.

When a lookup is needed, the block raises a request toward the external translation buffer and expects its answer in the same cycle. The answer holds a physical address, read/write permissions and a 2-bit result code. The decoded result is stored in a single output register stage with a valid flag.

A separate bad-address flag reports user-mode accesses to the kernel half. When that flag is set it overrides every other field of the result.

Top module: `seg_addr_xlate`

## Requirements
- R1: With in_user=1 and in_vaddr[31]=1, the result has out_bad=1, out_rd=0, out_wr=0, out_paddr=0 and out_code=1 (no-match), and tlb_req stays low. This holds in every mode and for either error-level value.
- R2: For in_vaddr[31]=0 with in_errlvl=1, the result is identity (out_paddr=in_vaddr) with out_rd=out_wr=1 and out_code=0 (match) in every mode, and tlb_req stays low.
- R3: For in_vaddr[31]=0 with in_errlvl=0:
  - mode 1 (fixed) gives out_paddr = in_vaddr + 0x40000000, modulo 2^32;
  - mode 0 (none) and mode 3 (treated as none) give identity;
  - in all these cases out_rd=out_wr=1 and out_code=0.
- R4: Addresses 0x80000000 to 0xBFFFFFFF with in_user=0 give out_paddr = in_vaddr & 0x1FFFFFFF, out_rd=out_wr=1 and out_code=0 in every mode, and tlb_req stays low.
- R5: Addresses 0xC0000000 and above with in_user=0 give identity with out_rd=out_wr=1 and out_code=0 in modes 0, 1 and 3.
- R6: In mode 2 (buffer), a valid request raises tlb_req in the same cycle, with tlb_vaddr=in_vaddr, for two address groups:
  - user-region addresses with in_errlvl=0;
  - kernel addresses from 0xC0000000 upward with in_user=0.
  If tlb_code=0, the result takes tlb_paddr, tlb_rd and tlb_wr, with out_code=0.
- R7: In mode 2, if tlb_code is nonzero (1 no-match, 2 invalid, 3 modified), that code is passed to out_code, while out_paddr=0, out_rd=0, out_wr=0 and out_bad=0.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. Reset sets out_valid and all result fields to 0.
- R9: A cycle with in_valid low leaves the result fields unchanged, and tlb_req stays low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_vaddr | input | 32 | Virtual address |
| in_user | input | 1 | Request issued in user mode |
| in_errlvl | input | 1 | Error level active |
| in_mode | input | 2 | 0 none, 1 fixed, 2 buffer, 3 none |
| tlb_req | output | 1 | Lookup request to the translation buffer |
| tlb_vaddr | output | 32 | Address presented for lookup |
| tlb_paddr | input | 32 | Lookup physical address |
| tlb_rd | input | 1 | Lookup read permission |
| tlb_wr | input | 1 | Lookup write permission |
| tlb_code | input | 2 | Lookup result code |
| out_valid | output | 1 | Registered result valid |
| out_paddr | output | 32 | Physical address |
| out_rd | output | 1 | Read permitted |
| out_wr | output | 1 | Write permitted |
| out_bad | output | 1 | Bad address, overrides the other fields |
| out_code | output | 2 | Result code |

## Verification
The hardest case to reach from the ports is a nonzero lookup code arriving for a mapped address while the error level and user flag steer other addresses away from the lookup path. The bench's translation-buffer model derives its result code and permissions from low address bits, so a single address sweep produces every code together with every segment. Each boundary address on either side of 0x80000000, 0xA0000000 and 0xC0000000 is applied under all four modes and all combinations of the user and error-level flags. A pseudo-random address set is swept in the same way.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      MMU_NONE  = 2'd0,
      MMU_FIXED = 2'd1,
      MMU_TLB   = 2'd2,
      MMU_RSVD  = 2'd3
   } mmu_mode_e;

   typedef enum logic [1:0] {
      RES_MATCH    = 2'd0,
      RES_NOMATCH  = 2'd1,
      RES_INVALID  = 2'd2,
      RES_MODIFIED = 2'd3
   } res_code_e;

   typedef enum logic [1:0] {
      SEG_USER   = 2'd0,
      SEG_KUNMAP = 2'd1,
      SEG_KMAP   = 2'd2
   } seg_e;
endpackage

// File: rtl/seg_classify.sv
module seg_classify
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              user,
   input  logic              errlvl,
   output seg_e              seg,
   output logic              bad,
   output logic              ident
);
   localparam int TOP = ADDR_W - 1;

   always_comb begin
      if (!vaddr[TOP])          seg = SEG_USER;
      else if (!vaddr[TOP-1])   seg = SEG_KUNMAP;
      else                      seg = SEG_KMAP;
   end

   // user mode may only touch the low half
   assign bad   = user && vaddr[TOP];
   // error level bypasses translation of the user region
   assign ident = (seg == SEG_USER) && errlvl;
endmodule

// File: rtl/seg_mapper.sv
module seg_mapper
   import seg_xlate_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] FIX_OFS  = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] KUNM_MASK = 32'h1FFF_FFFF,
   parameter bit              ENABLE_TLB = 1'b1
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] vaddr,
   input  mmu_mode_e         mode,
   input  seg_e              seg,
   input  logic              bad,
   input  logic              ident,
   input  logic [ADDR_W-1:0] tlb_paddr,
   input  logic              tlb_rd,
   input  logic              tlb_wr,
   input  logic [1:0]        tlb_code,
   output logic              tlb_req,
   output logic [ADDR_W-1:0] paddr,
   output logic              rd,
   output logic              wr,
   output res_code_e         code
);
   logic              use_tlb;
   logic [ADDR_W-1:0] t_paddr;
   logic              t_rd, t_wr;
   res_code_e         t_code;
   logic              mapped;

   assign mapped = !bad && !ident && (seg != SEG_KUNMAP);

   generate
      if (ENABLE_TLB) begin : g_tlb
         assign use_tlb = mapped && (mode == MMU_TLB);
         always_comb begin
            t_code = res_code_e'(tlb_code);
            if (t_code == RES_MATCH) begin
               t_paddr = tlb_paddr;
               t_rd    = tlb_rd;
               t_wr    = tlb_wr;
            end else begin
               t_paddr = '0;
               t_rd    = 1'b0;
               t_wr    = 1'b0;
            end
         end
      end else begin : g_notlb
         assign use_tlb = 1'b0;
         assign t_paddr = '0;
         assign t_rd    = 1'b0;
         assign t_wr    = 1'b0;
         assign t_code  = RES_NOMATCH;
      end
   endgenerate

   assign tlb_req = valid && use_tlb;

   always_comb begin
      paddr = vaddr;
      rd    = 1'b1;
      wr    = 1'b1;
      code  = RES_MATCH;
      if (bad) begin
         paddr = '0;
         rd    = 1'b0;
         wr    = 1'b0;
         code  = RES_NOMATCH;
      end else if (seg == SEG_KUNMAP) begin
         paddr = vaddr & KUNM_MASK;
      end else if (use_tlb) begin
         paddr = t_paddr;
         rd    = t_rd;
         wr    = t_wr;
         code  = t_code;
      end else if (mapped && mode == MMU_FIXED && seg == SEG_USER) begin
         paddr = vaddr + FIX_OFS;
      end
   end
endmodule

// File: rtl/seg_out_reg.sv
module seg_out_reg
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [ADDR_W-1:0] d_paddr,
   input  logic              d_rd,
   input  logic              d_wr,
   input  logic              d_bad,
   input  res_code_e         d_code,
   output logic              q_valid,
   output logic [ADDR_W-1:0] q_paddr,
   output logic              q_rd,
   output logic              q_wr,
   output logic              q_bad,
   output logic [1:0]        q_code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_paddr <= '0;
         q_rd    <= 1'b0;
         q_wr    <= 1'b0;
         q_bad   <= 1'b0;
         q_code  <= '0;
      end else begin
         q_valid <= d_valid;
         if (d_valid) begin
            q_paddr <= d_paddr;
            q_rd    <= d_rd;
            q_wr    <= d_wr;
            q_bad   <= d_bad;
            q_code  <= d_code;
         end
      end
   end

   // R8: valid follows the request by one cycle
   assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |=> q_valid);
   // R9: idle cycles keep the result
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |=> (!q_valid && $stable(q_paddr) && $stable(q_code)));
endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate
   import seg_xlate_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] FIX_OFS    = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] KUNM_MASK  = 32'h1FFF_FFFF,
   parameter bit                ENABLE_TLB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_vaddr,
   input  logic              in_user,
   input  logic              in_errlvl,
   input  logic [1:0]        in_mode,
   output logic              tlb_req,
   output logic [ADDR_W-1:0] tlb_vaddr,
   input  logic [ADDR_W-1:0] tlb_paddr,
   input  logic              tlb_rd,
   input  logic              tlb_wr,
   input  logic [1:0]        tlb_code,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_paddr,
   output logic              out_rd,
   output logic              out_wr,
   output logic              out_bad,
   output logic [1:0]        out_code
);
   localparam int TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 8) begin : g_chk_width
         $error("seg_addr_xlate: ADDR_W must be at least 8");
      end
      if (KUNM_MASK[TOP -: 2] != 2'b00) begin : g_chk_mask
         $error("seg_addr_xlate: unmapped mask must clear the two segment bits");
      end
   endgenerate

   seg_e              seg;
   logic              bad, ident;
   logic [ADDR_W-1:0] m_paddr;
   logic              m_rd, m_wr;
   res_code_e         m_code;

   seg_classify #(.ADDR_W(ADDR_W)) u_cls (
      .vaddr (in_vaddr),
      .user  (in_user),
      .errlvl(in_errlvl),
      .seg   (seg),
      .bad   (bad),
      .ident (ident)
   );

   seg_mapper #(
      .ADDR_W    (ADDR_W),
      .FIX_OFS   (FIX_OFS),
      .KUNM_MASK (KUNM_MASK),
      .ENABLE_TLB(ENABLE_TLB)
   ) u_map (
      .valid    (in_valid),
      .vaddr    (in_vaddr),
      .mode     (mmu_mode_e'(in_mode)),
      .seg      (seg),
      .bad      (bad),
      .ident    (ident),
      .tlb_paddr(tlb_paddr),
      .tlb_rd   (tlb_rd),
      .tlb_wr   (tlb_wr),
      .tlb_code (tlb_code),
      .tlb_req  (tlb_req),
      .paddr    (m_paddr),
      .rd       (m_rd),
      .wr       (m_wr),
      .code     (m_code)
   );

   assign tlb_vaddr = in_vaddr;

   seg_out_reg #(.ADDR_W(ADDR_W)) u_oreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_valid(in_valid),
      .d_paddr(m_paddr),
      .d_rd   (m_rd),
      .d_wr   (m_wr),
      .d_bad  (bad),
      .d_code (m_code),
      .q_valid(out_valid),
      .q_paddr(out_paddr),
      .q_rd   (out_rd),
      .q_wr   (out_wr),
      .q_bad  (out_bad),
      .q_code (out_code)
   );

   // R1: kernel-half access from user mode is flagged and silent
   assert_user_bad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_user && in_vaddr[TOP]) |=> (out_bad && !out_rd && !out_wr && out_paddr == '0));
   assert_no_req_on_bad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_user && in_vaddr[TOP]) |-> !tlb_req);
   // R4: unmapped kernel window never asks for a lookup and masks the address
   assert_kunmap_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_user && in_vaddr[TOP -: 2] == 2'b10) |=>
      (out_paddr == ($past(in_vaddr) & KUNM_MASK) && out_code == 2'd0));
   // R6: a lookup request only appears for a valid request in buffer mode
   assert_req_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req |-> (in_valid && in_mode == 2'd2 && in_vaddr[TOP -: 2] != 2'b10));
   // R7: a failed lookup grants nothing
   assert_miss_noperm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_code != 2'd0 && !out_bad) |-> (!out_rd && !out_wr));
   // R9: idle requests never reach the buffer
   assert_idle_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> !tlb_req);
endmodule

// File: tb/seg_addr_xlate_bench.sv
`timescale 1ns/1ps
module seg_addr_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_vaddr = '0;
   logic        in_user = 1'b0;
   logic        in_errlvl = 1'b0;
   logic [1:0]  in_mode = '0;
   logic        tlb_req;
   logic [31:0] tlb_vaddr;
   logic [31:0] tlb_paddr;
   logic        tlb_rd, tlb_wr;
   logic [1:0]  tlb_code;
   logic        out_valid, out_rd, out_wr, out_bad;
   logic [31:0] out_paddr;
   logic [1:0]  out_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   // translation-buffer model: answer derived from the presented address
   always_comb begin
      tlb_paddr = {4'hA, tlb_vaddr[27:0]};
      tlb_code  = tlb_vaddr[13:12];
      tlb_rd    = ~tlb_vaddr[4];
      tlb_wr    = tlb_vaddr[5];
   end

   seg_addr_xlate u_seg_addr_xlate (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_vaddr(in_vaddr), .in_user(in_user),
      .in_errlvl(in_errlvl), .in_mode(in_mode),
      .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr), .tlb_paddr(tlb_paddr),
      .tlb_rd(tlb_rd), .tlb_wr(tlb_wr), .tlb_code(tlb_code),
      .out_valid(out_valid), .out_paddr(out_paddr), .out_rd(out_rd),
      .out_wr(out_wr), .out_bad(out_bad), .out_code(out_code)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   typedef struct {
      logic [31:0] pa;
      logic rd, wr, bad, req;
      logic [1:0] code;
      string tag;
   } exp_t;

   function automatic exp_t model(logic [31:0] a, logic u, logic e, logic [1:0] m);
      exp_t x;
      x.pa = a; x.rd = 1; x.wr = 1; x.bad = 0; x.req = 0; x.code = 0;
      if (u && a >= 32'h8000_0000) begin
         x.pa = 0; x.rd = 0; x.wr = 0; x.bad = 1; x.code = 1; x.tag = "R1";
      end else if (a < 32'h8000_0000 && e) begin
         x.tag = "R2";
      end else if (a >= 32'h8000_0000 && a < 32'hC000_0000) begin
         x.pa = a & 32'h1FFF_FFFF; x.tag = "R4";
      end else if (m == 2'd2) begin
         x.req = 1;
         x.code = a[13:12];
         if (x.code == 0) begin
            x.pa = {4'hA, a[27:0]}; x.rd = ~a[4]; x.wr = a[5]; x.tag = "R6";
         end else begin
            x.pa = 0; x.rd = 0; x.wr = 0; x.tag = "R7";
         end
      end else if (a < 32'h8000_0000) begin
         if (m == 2'd1) x.pa = a + 32'h4000_0000;
         x.tag = "R3";
      end else begin
         x.tag = "R5";
      end
      return x;
   endfunction

   task automatic apply(input logic [31:0] a, input logic u, input logic e, input logic [1:0] m);
      exp_t x;
      x = model(a, u, e, m);
      @(negedge clk);
      in_valid = 1; in_vaddr = a; in_user = u; in_errlvl = e; in_mode = m;
      #1;
      chk({x.tag, " tlb_req"}, {31'b0, tlb_req}, {31'b0, x.req});
      @(negedge clk);
      chk({x.tag, " R8 out_valid"}, {31'b0, out_valid}, 32'd1);
      chk({x.tag, " paddr"}, out_paddr, x.pa);
      chk({x.tag, " rd"}, {31'b0, out_rd}, {31'b0, x.rd});
      chk({x.tag, " wr"}, {31'b0, out_wr}, {31'b0, x.wr});
      chk({x.tag, " bad"}, {31'b0, out_bad}, {31'b0, x.bad});
      chk({x.tag, " code"}, {30'b0, out_code}, {30'b0, x.code});
   endtask

   task automatic idle_check(input logic [31:0] a);
      logic [31:0] pa_prev;
      logic [1:0]  code_prev;
      pa_prev = out_paddr; code_prev = out_code;
      in_valid = 0; in_vaddr = a; in_user = 0; in_errlvl = 0; in_mode = 2'd2;
      #1;
      chk("R9 idle tlb_req", {31'b0, tlb_req}, 32'd0);
      @(negedge clk);
      chk("R8 idle out_valid", {31'b0, out_valid}, 32'd0);
      chk("R9 idle paddr hold", out_paddr, pa_prev);
      chk("R9 idle code hold", {30'b0, out_code}, {30'b0, code_prev});
   endtask

   logic [31:0] pts [20] = '{
      32'h0000_0000, 32'h0000_0001, 32'h0000_3010, 32'h3FFF_FFFF,
      32'h4000_0000, 32'h7FFF_CFFF, 32'h7FFF_FFFF, 32'h8000_0000,
      32'h8000_1234, 32'h9FFF_FFFF, 32'hA000_0000, 32'hA123_4567,
      32'hBFFF_FFFF, 32'hC000_0000, 32'hC000_1000, 32'hDEAD_BEEF,
      32'hE000_2030, 32'hFFFF_EFDF, 32'hFFFF_FFFF, 32'hC000_0030
   };

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 reset out_valid", {31'b0, out_valid}, 32'd0);
      chk("R8 reset out_paddr", out_paddr, 32'd0);
      chk("R8 reset out_code", {30'b0, out_code}, 32'd0);
      chk("R8 reset out_bad", {31'b0, out_bad}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 post-reset out_valid", {31'b0, out_valid}, 32'd0);
      for (int i = 0; i < 20; i++) begin
         for (int c = 0; c < 16; c++)
            apply(pts[i], c[3], c[2], c[1:0]);
         idle_check(pts[(i + 7) % 20]);
      end
      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         for (int c = 0; c < 16; c++)
            apply(lfsr, c[3], c[2], c[1:0]);
         if (i % 25 == 0) idle_check(~lfsr);
      end
      @(negedge clk);
      in_valid = 0;
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule